// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Lock Flag

This block compares two divided-down clock signals, the reference divider output and the feedback (main) divider output, inside one reference clock domain. A falling edge on the reference divider sets a pump-up request. A falling edge on the feedback divider sets a pump-down request. UP means the oscillator must speed up and DOWN means it must slow down. Once both requests are set, an internal clear is raised. The two requests are then dropped together one reference cycle later. This means that even at zero phase error both outputs pulse briefly, so the loop has no deadband.

A lock flag reports when the error has stayed below one reference cycle for a programmable number of consecutive comparisons. The flag drops as soon as a one-sided pump request appears. A small register holds the pump current magnitude code. The current is linear in that code, and the reset value gives the largest current.

Top module: `pfd_lock`

## Requirements
- R1: A falling edge of `ref_div`, meaning a sample of 1 followed by a sample of 0 on consecutive rising edges of `clk`, sets `up` on that second edge.
- R2: A falling edge of `fb_div`, detected the same way, sets `dn` on that second edge.
- R3: Once `up` and `dn` are both high, both stay high for exactly one more cycle and then go low together. The exception is a new falling edge sampled on the clearing edge, which sets its own output again.
- R4: Only a 1-to-0 change between consecutive samples counts as an edge. The sample history resets to 0, so a divider input that is low at reset produces no request.
- R5: `lock` goes low on the edge that follows any cycle in which exactly one of `up` and `dn` is high.
- R6: `lock` goes high on the clearing edge of the LOCK_CNT-th consecutive comparison with no one-sided cycle, and stays high while comparisons stay clean.
- R7: `cp_code` resets to all ones (7 for the 3-bit default, the largest pump current). It takes `cp_wdata` on the edge where `cp_wr` is high, and holds otherwise.
- R8: While `rst_n` is low, `up`, `dn` and `lock` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_div | input | 1 | Reference divider output |
| fb_div | input | 1 | Feedback divider output |
| cp_wr | input | 1 | Load strobe for the pump magnitude code |
| cp_wdata | input | CP_W | New pump magnitude code |
| up | output | 1 | Pump-up request (source current) |
| dn | output | 1 | Pump-down request (sink current) |
| lock | output | 1 | Phase error below one reference cycle, held |
| cp_code | output | CP_W | Pump magnitude code |

## Verification
Edge requests appear on the edge that samples the low half of a falling divider. Clears follow two edges after both requests are set. Lock drops one edge after a one-sided cycle. The code loads one edge after its strobe. The bench keeps a behavioural model that advances on each rising edge, using only the divider and strobe values it drove itself. It compares every output on the following falling edge, after all of these registered results have settled. Scenarios include aligned dividers, a lag of one cycle, a lead of three cycles, unequal periods and code writes. A lag of one cycle is the closest case that lies outside the lock window.

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int LOCK_CNT = 4,
  parameter int CP_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_div,
  input  logic            fb_div,
  input  logic            cp_wr,
  input  logic [CP_W-1:0] cp_wdata,
  output logic            up,
  output logic            dn,
  output logic            lock,
  output logic [CP_W-1:0] cp_code
);
  localparam int CW = $clog2(LOCK_CNT + 1);
  localparam logic [CW-1:0] LIM = CW'(LOCK_CNT);

  logic ref_q, fb_q, clr_r, miss_r;
  logic [CW-1:0] good_cnt;
  logic [CW-1:0] good_nxt;

  wire ref_fall = ref_q & ~ref_div;
  wire fb_fall  = fb_q & ~fb_div;
  wire one_side = up ^ dn;

  assign good_nxt = (good_cnt == LIM) ? LIM : good_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
      up    <= 1'b0;
      dn    <= 1'b0;
      clr_r <= 1'b0;
    end else begin
      ref_q <= ref_div;
      fb_q  <= fb_div;
      up    <= clr_r ? ref_fall : (up | ref_fall);
      dn    <= clr_r ? fb_fall  : (dn | fb_fall);
      clr_r <= up & dn & ~clr_r;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      miss_r   <= 1'b0;
      good_cnt <= '0;
      lock     <= 1'b0;
    end else if (one_side) begin
      miss_r   <= 1'b1;
      good_cnt <= '0;
      lock     <= 1'b0;
    end else if (clr_r) begin
      miss_r   <= 1'b0;
      good_cnt <= miss_r ? '0 : good_nxt;
      lock     <= !miss_r && (good_nxt == LIM);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     cp_code <= '1;
    else if (cp_wr) cp_code <= cp_wdata;

  AST_UP_ON_FALL:   assert property (@(posedge clk) disable iff (!rst_n) (ref_q && !ref_div) |=> up); // R1
  AST_DN_ON_FALL:   assert property (@(posedge clk) disable iff (!rst_n) (fb_q && !fb_div) |=> dn); // R2
  AST_BOTH_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) $rose(up && dn) |=> (up && dn)); // R3
  AST_BOTH_DROP:    assert property (@(posedge clk) disable iff (!rst_n) (up && dn && clr_r && !ref_fall && !fb_fall) |=> (!up && !dn)); // R3
  AST_LOCK_DROP:    assert property (@(posedge clk) disable iff (!rst_n) one_side |=> !lock); // R5
  AST_LOCK_RISE:    assert property (@(posedge clk) disable iff (!rst_n) $rose(lock) |-> $past(clr_r)); // R6
  AST_CP_HOLD:      assert property (@(posedge clk) disable iff (!rst_n) !cp_wr |=> $stable(cp_code)); // R7
endmodule

// File: tb/pfd_lock_test.sv
module pfd_lock_test;
  localparam int LOCKN = 4;
  logic clk = 1'b0, rst_n = 1'b0, ref_div = 1'b0, fb_div = 1'b0, cp_wr = 1'b0;
  logic [2:0] cp_wdata = 3'd0;
  logic up, dn, lock;
  logic [2:0] cp_code;
  int checks = 0, fails = 0;
  bit done = 0;

  pfd_lock #(.LOCK_CNT(LOCKN), .CP_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
    .cp_wr(cp_wr), .cp_wdata(cp_wdata),
    .up(up), .dn(dn), .lock(lock), .cp_code(cp_code));

  always #2 clk = ~clk;

  // behavioural reference
  bit m_pr, m_pf, m_up, m_dn, m_pend, m_miss, m_lock;
  int m_good;
  int m_cp = 7;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pr = 0; m_pf = 0; m_up = 0; m_dn = 0; m_pend = 0;
      m_miss = 0; m_good = 0; m_lock = 0; m_cp = 7;
    end else begin
      bit rf, ff, nu, nd, np;
      rf = m_pr && !ref_div;
      ff = m_pf && !fb_div;
      nu = m_pend ? rf : (m_up || rf);
      nd = m_pend ? ff : (m_dn || ff);
      np = m_up && m_dn && !m_pend;
      if (m_up != m_dn) begin
        m_miss = 1; m_good = 0; m_lock = 0;
      end else if (m_pend) begin
        if (m_miss) m_good = 0;
        else m_good = (m_good >= LOCKN) ? LOCKN : m_good + 1;
        m_lock = !m_miss && (m_good >= LOCKN);
        m_miss = 0;
      end
      if (cp_wr) m_cp = cp_wdata;
      m_up = nu; m_dn = nd; m_pend = np;
      m_pr = ref_div; m_pf = fb_div;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    chk("R1 up", up, m_up);
    chk("R2 dn", dn, m_dn);
    chk("R5/R6 lock", lock, m_lock);
    chk("R7 cp_code", cp_code, m_cp);
  endtask

  // drive two square waves for n cycles; compare every cycle
  task automatic run(int pr, int pf, int off_r, int off_f, int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      cmp_all();
      ref_div = ((c + off_r) % pr) < pr / 2;
      fb_div  = ((c + off_f) % pf) < pf / 2;
      cp_wr   = 1'b0;
    end
  endtask

  int hi_seen;

  initial begin
    // R8 reset state, R4 low inputs during reset
    repeat (3) @(negedge clk);
    chk("R8 up in reset", up, 0);
    chk("R8 dn in reset", dn, 0);
    chk("R8 lock in reset", lock, 0);
    chk("R7 cp reset", cp_code, 7);
    rst_n = 1'b1;
    // R4: inputs held low after reset, nothing happens
    run(16, 16, 8, 8, 6);
    chk("R4 no spurious up", up, 0);
    chk("R4 no spurious dn", dn, 0);
    // R3/R6 aligned dividers: lock acquired
    run(16, 16, 0, 0, 16 * 8);
    chk("R6 lock aligned", lock, 1);
    // R5 feedback lags by one cycle: outside window
    run(16, 16, 1, 0, 16 * 4);
    chk("R5 lock lag 1", lock, 0);
    // R6 reacquire
    run(16, 16, 0, 0, 16 * 8);
    chk("R6 lock reacquired", lock, 1);
    // R2 feedback leads by three cycles
    hi_seen = 0;
    for (int k = 0; k < 4; k++) begin
      run(16, 16, 0, 3, 16);
      if (dn && !up) hi_seen = 1;
    end
    chk("R5 lock lead 3", lock, 0);
    // R7 code writes
    @(negedge clk); cmp_all(); cp_wdata = 3'd2; cp_wr = 1'b1;
    @(negedge clk); cmp_all(); chk("R7 cp loaded", cp_code, 2); cp_wr = 1'b0; cp_wdata = 3'd5;
    @(negedge clk); cmp_all(); chk("R7 cp held", cp_code, 2);
    @(negedge clk); cmp_all(); cp_wdata = 3'd0; cp_wr = 1'b1;
    @(negedge clk); cmp_all(); chk("R7 cp zero", cp_code, 0); cp_wr = 1'b0;
    // R1/R2 unequal frequencies
    run(14, 18, 0, 0, 600);
    run(20, 12, 0, 5, 600);
    // R3 short periods: new edge on clearing edge
    run(4, 4, 0, 0, 80);
    run(4, 6, 0, 1, 120);
    // R8 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R8 up after reset", up, 0);
    chk("R8 lock after reset", lock, 0);
    chk("R7 cp after reset", cp_code, 7);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule